// File: doc/BRIEF.md
# External Bus Read Cycle Sequencer

This block sits between a processor core and an external asynchronous-style memory bus. It turns read requests into external read cycles. There are two request ports, one for instruction fetches and one for data loads. The block drives an active-low address strobe, the byte address, a 4-bit address-space code, a read/write line and active-low byte enables. It then waits for the device to pull its active-low ready line low.

Every read moves a whole 32-bit word, whatever the size of the load that caused it. Requests carry a word address only. The top two bits of the word address pick one of several regions. Each region has a 2-bit bus-width setting: 32, 16 or 8 bits. On a narrow region, the word is collected over several beats, most significant byte first.

A data request can ask for a double word. It then runs as two word reads, one after the other. If the device flags an error together with ready, the transfer stops at once and returns an error response tagged with the request kind. A grant input must be high before a new transfer may start.

Top module: `xbus_rd_seq`

## Requirements
- R1: When `d_valid` and `i_valid` are both high in an idle, granted cycle, `d_ack` is high and `i_ack` is low. The instruction request is accepted only after the data transfer has fully responded.
- R2: Every beat starts with `as_n` low for exactly one clock. `bus_adr` and `asi` carry that beat's address and the request's space code while `as_n` is low. `rdwr` is 1 (read) for the whole transfer.
- R3: `be_n` reads 4'b0000 on a 32-bit region, 4'b0011 on a 16-bit region and 4'b0111 on an 8-bit region.
- R4: A beat ends only at a rising edge where `rdy_n` is sampled 0. `bus_adr` holds steady until then. With W wait cycles on a one-beat read, `rsp_valid` appears 2+W cycles after the cycle in which the request is acknowledged.
- R5: On a 16-bit region (width code 1), a word takes two beats at byte offsets 0 and 2. Each beat's halfword is taken from `bus_d[31:16]`, and the first beat fills bits 31:16 of the result.
- R6: On an 8-bit region (width code 2), a word takes four beats at byte offsets 0, 1, 2 and 3. Each byte is taken from `bus_d[31:24]`, and the first beat fills bits 31:24 of the result.
- R7: On a 32-bit region (width code 0 or 3), a word takes a single beat at byte offset 0, and `rsp_data` equals `bus_d` as sampled with ready. The region index is word-address bits [25:24], and region k uses `cfg_width[2k+1:2k]`.
- R8: A data request with `d_dbl` set runs two word reads, at word addresses A and A+1, with no idle cycle between them. It gives two responses, with `rsp_second` 0 and then 1.
- R9: If `berr` is 1 when ready is sampled, the transfer ends at that beat. The block returns one response with `rsp_err`=1 and `rsp_is_data` showing the request kind, and starts no further beat.
- R10: While `grant` is low, neither `d_ack` nor `i_ack` rises and no new strobe starts.
- R11: After reset, `as_n`=1, `rdwr`=0, `be_n`=4'b1111 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Bus granted to this block; new transfers start only when high |
| d_valid | input | 1 | Data load request |
| d_wadr | input | ADDR_W-2 | Data word address |
| d_asi | input | ASI_W | Data address-space code |
| d_dbl | input | 1 | Double-word load |
| d_ack | output | 1 | Data request accepted this cycle |
| i_valid | input | 1 | Instruction fetch request |
| i_wadr | input | ADDR_W-2 | Instruction word address |
| i_asi | input | ASI_W | Instruction address-space code |
| i_ack | output | 1 | Instruction request accepted this cycle |
| cfg_width | input | 2*NREG | Per-region width code: 0/3 = 32 bit, 1 = 16 bit, 2 = 8 bit |
| as_n | output | 1 | Address strobe, active low |
| bus_adr | output | ADDR_W | Byte address of the current beat |
| asi | output | ASI_W | Address-space code on the bus |
| rdwr | output | 1 | 1 = read cycle in progress |
| be_n | output | 4 | Byte enables, active low |
| rdy_n | input | 1 | Device ready, active low |
| berr | input | 1 | Device error, valid with ready |
| bus_d | input | 32 | Read data from device |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Assembled word |
| rsp_err | output | 1 | Transfer ended by an error |
| rsp_is_data | output | 1 | Response belongs to the data port |
| rsp_second | output | 1 | Second word of a double load |

## Verification
Two things can meet in one cycle: an instruction fetch and a data load, both waiting on an idle, granted bus. Another case is a beat's ready edge that also has to launch the next beat or the second word. The bench raises both valid lines in the same cycle and checks the acknowledges at once. It then checks the order and tags of the two responses. Back-to-back beats are provoked by a zero-wait device model that answers in the strobe cycle itself, and every strobe's address and enables are logged against the expected beat sequence.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    BW_32  = 2'd0,
    BW_16  = 2'd1,
    BW_8   = 2'd2,
    BW_32X = 2'd3
  } bw_e;

endpackage

// File: rtl/xbus_arb.sv
module xbus_arb (
  input  logic idle,
  input  logic grant,
  input  logic d_valid,
  input  logic i_valid,
  output logic d_take,
  output logic i_take
);
  logic open_q;

  always_comb begin
    open_q = idle & grant;
    d_take = open_q & d_valid;
    i_take = open_q & i_valid & ~d_valid;
  end
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int RB   = 2
) (
  input  logic [2*NREG-1:0] cfg_width,
  input  logic [RB-1:0]     region,
  output bw_e               wcode,
  output logic [1:0]        beats_m1,
  output logic [2:0]        step,
  output logic [3:0]        be_n
);
  logic [1:0] codes [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign codes[g] = cfg_width[2*g +: 2];
  end

  always_comb begin
    wcode = bw_e'(codes[region]);
    unique case (wcode)
      BW_16: begin
        beats_m1 = 2'd1;
        step     = 3'd2;
        be_n     = 4'b0011;
      end
      BW_8: begin
        beats_m1 = 2'd3;
        step     = 3'd1;
        be_n     = 4'b0111;
      end
      default: begin
        beats_m1 = 2'd0;
        step     = 3'd4;
        be_n     = 4'b0000;
      end
    endcase
  end
endmodule

// File: rtl/xbus_pack.sv
module xbus_pack
  import xbus_pkg::*;
(
  input  bw_e         wcode,
  input  logic [31:0] acc,
  input  logic [31:0] bus_d,
  output logic [31:0] next
);
  always_comb begin
    unique case (wcode)
      BW_16:   next = {acc[15:0], bus_d[31:16]};
      BW_8:    next = {acc[23:0], bus_d[31:24]};
      default: next = bus_d;
    endcase
  end
endmodule

// File: rtl/xbus_rd_seq.sv
module xbus_rd_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int ASI_W  = 4,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              d_valid,
  input  logic [ADDR_W-3:0] d_wadr,
  input  logic [ASI_W-1:0]  d_asi,
  input  logic              d_dbl,
  output logic              d_ack,
  input  logic              i_valid,
  input  logic [ADDR_W-3:0] i_wadr,
  input  logic [ASI_W-1:0]  i_asi,
  output logic              i_ack,
  input  logic [2*NREG-1:0] cfg_width,
  output logic              as_n,
  output logic [ADDR_W-1:0] bus_adr,
  output logic [ASI_W-1:0]  asi,
  output logic              rdwr,
  output logic [3:0]        be_n,
  input  logic              rdy_n,
  input  logic              berr,
  input  logic [31:0]       bus_d,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              rsp_is_data,
  output logic              rsp_second
);
  localparam int WA_W = ADDR_W - 2;
  localparam int RB   = (NREG > 1) ? $clog2(NREG) : 1;

  logic d_take, i_take, take;
  logic [WA_W-1:0] sel_wadr;
  bw_e             lk_code;
  logic [1:0]      lk_beats;
  logic [2:0]      lk_step;
  logic [3:0]      lk_be;

  logic              busy_q, isd_q, dbl_q, word_q;
  logic [1:0]        beat_q, beats_m1_q;
  logic [2:0]        step_q;
  bw_e               wcode_q;
  logic [WA_W-1:0]   base_q;
  logic [31:0]       acc_q, acc_nx;
  logic              as_n_q, rdwr_q, rsp_valid_q, rsp_err_q, rsp_isd_q, rsp_sec_q;
  logic [ADDR_W-1:0] adr_q;
  logic [ASI_W-1:0]  asi_q;
  logic [3:0]        be_n_q;
  logic [31:0]       rsp_data_q;

  xbus_arb u_arb (
    .idle   (~busy_q),
    .grant  (grant),
    .d_valid(d_valid),
    .i_valid(i_valid),
    .d_take (d_take),
    .i_take (i_take)
  );

  assign take     = d_take | i_take;
  assign sel_wadr = d_take ? d_wadr : i_wadr;

  xbus_lane #(.NREG(NREG), .RB(RB)) u_lane (
    .cfg_width(cfg_width),
    .region   (sel_wadr[WA_W-1 -: RB]),
    .wcode    (lk_code),
    .beats_m1 (lk_beats),
    .step     (lk_step),
    .be_n     (lk_be)
  );

  xbus_pack u_pack (
    .wcode(wcode_q),
    .acc  (acc_q),
    .bus_d(bus_d),
    .next (acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      isd_q       <= 1'b0;
      dbl_q       <= 1'b0;
      word_q      <= 1'b0;
      beat_q      <= '0;
      beats_m1_q  <= '0;
      step_q      <= 3'd4;
      wcode_q     <= BW_32;
      base_q      <= '0;
      acc_q       <= '0;
      as_n_q      <= 1'b1;
      rdwr_q      <= 1'b0;
      adr_q       <= '0;
      asi_q       <= '0;
      be_n_q      <= 4'b1111;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_err_q   <= 1'b0;
      rsp_isd_q   <= 1'b0;
      rsp_sec_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      as_n_q      <= 1'b1;
      if (!busy_q) begin
        if (take) begin
          busy_q     <= 1'b1;
          isd_q      <= d_take;
          dbl_q      <= d_take & d_dbl;
          word_q     <= 1'b0;
          beat_q     <= '0;
          beats_m1_q <= lk_beats;
          step_q     <= lk_step;
          wcode_q    <= lk_code;
          base_q     <= sel_wadr;
          acc_q      <= '0;
          as_n_q     <= 1'b0;
          rdwr_q     <= 1'b1;
          adr_q      <= {sel_wadr, 2'b00};
          asi_q      <= d_take ? d_asi : i_asi;
          be_n_q     <= lk_be;
        end
      end else if (!rdy_n) begin
        if (berr) begin
          busy_q      <= 1'b0;
          rdwr_q      <= 1'b0;
          be_n_q      <= 4'b1111;
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= '0;
          rsp_err_q   <= 1'b1;
          rsp_isd_q   <= isd_q;
          rsp_sec_q   <= word_q;
        end else if (beat_q != beats_m1_q) begin
          beat_q <= beat_q + 2'd1;
          acc_q  <= acc_nx;
          adr_q  <= adr_q + ADDR_W'(step_q);
          as_n_q <= 1'b0;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= acc_nx;
          rsp_err_q   <= 1'b0;
          rsp_isd_q   <= isd_q;
          rsp_sec_q   <= word_q;
          if (dbl_q && !word_q) begin
            word_q <= 1'b1;
            beat_q <= '0;
            acc_q  <= '0;
            base_q <= base_q + WA_W'(1);
            adr_q  <= {base_q + WA_W'(1), 2'b00};
            as_n_q <= 1'b0;
          end else begin
            busy_q <= 1'b0;
            rdwr_q <= 1'b0;
            be_n_q <= 4'b1111;
          end
        end
      end
    end
  end

  assign d_ack       = d_take;
  assign i_ack       = i_take;
  assign as_n        = as_n_q;
  assign bus_adr     = adr_q;
  assign asi         = asi_q;
  assign rdwr        = rdwr_q;
  assign be_n        = be_n_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign rsp_err     = rsp_err_q;
  assign rsp_is_data = rsp_isd_q;
  assign rsp_second  = rsp_sec_q;
endmodule

// File: rtl/xbus_rd_seq_chk.sv
module xbus_rd_seq_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              grant,
  input logic              d_valid,
  input logic              d_ack,
  input logic              i_ack,
  input logic              as_n,
  input logic              rdy_n,
  input logic [3:0]        be_n,
  input logic              rdwr,
  input logic [ADDR_W-1:0] bus_adr,
  input logic              rsp_valid,
  input logic              rsp_err
);
  p_data_first_r1: assert property (@(posedge clk) disable iff (rst)
    i_ack |-> !d_valid);
  p_single_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !(d_ack && i_ack));
  p_strobe_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    (!as_n && rdy_n) |=> as_n);
  p_read_line_r2: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> rdwr);
  p_be_code_r3: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> (be_n == 4'b0000 || be_n == 4'b0011 || be_n == 4'b0111));
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rdwr && rdy_n) |=> $stable(bus_adr));
  p_rsp_after_ready_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!rdy_n));
  p_err_halts_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (as_n && !rdwr));
  p_grant_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !grant |-> (!d_ack && !i_ack));
endmodule

bind xbus_rd_seq xbus_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .grant    (grant),
  .d_valid  (d_valid),
  .d_ack    (d_ack),
  .i_ack    (i_ack),
  .as_n     (as_n),
  .rdy_n    (rdy_n),
  .be_n     (be_n),
  .rdwr     (rdwr),
  .bus_adr  (bus_adr),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err)
);

// File: tb/xbus_rd_seq_test.sv
`timescale 1ns/1ps
module xbus_rd_seq_test;
  logic        clk = 1'b0, rst = 1'b1, grant = 1'b1;
  logic        d_valid = 0, d_dbl = 0, i_valid = 0;
  logic [25:0] d_wadr = '0, i_wadr = '0;
  logic [3:0]  d_asi = '0, i_asi = '0;
  logic        d_ack, i_ack, as_n, rdwr, rsp_valid, rsp_err, rsp_is_data, rsp_second;
  logic [7:0]  cfg_width = {2'd3, 2'd2, 2'd1, 2'd0};
  logic [27:0] bus_adr;
  logic [3:0]  asi, be_n;
  logic        rdy_n = 1'b1, berr = 1'b0;
  logic [31:0] bus_d = '0, rsp_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  xbus_rd_seq uut (
    .clk(clk), .rst(rst), .grant(grant),
    .d_valid(d_valid), .d_wadr(d_wadr), .d_asi(d_asi), .d_dbl(d_dbl), .d_ack(d_ack),
    .i_valid(i_valid), .i_wadr(i_wadr), .i_asi(i_asi), .i_ack(i_ack),
    .cfg_width(cfg_width), .as_n(as_n), .bus_adr(bus_adr), .asi(asi), .rdwr(rdwr),
    .be_n(be_n), .rdy_n(rdy_n), .berr(berr), .bus_d(bus_d),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_is_data(rsp_is_data), .rsp_second(rsp_second)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // logs and device model
  logic [27:0] s_adr [16];
  logic [3:0]  s_be [16], s_asi [16];
  logic        s_rd [16];
  int          s_cnt = 0;
  logic [31:0] r_data [8];
  logic        r_err [8], r_isd [8], r_sec [8];
  int          r_cyc [8];
  int          r_cnt = 0;
  int          waitc = 0, err_beat = -1, beat_no = 0, cnt = 0, ack_cyc = 0;
  bit          pend = 0;
  logic [27:0] la;
  logic [3:0]  lb;

  function automatic logic [7:0] bb(input logic [27:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  function automatic logic [31:0] wd(input logic [25:0] w);
    return {bb({w, 2'd0}), bb({w, 2'd1}), bb({w, 2'd2}), bb({w, 2'd3})};
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!as_n) begin
        if (s_cnt < 16) begin
          s_adr[s_cnt] = bus_adr; s_be[s_cnt] = be_n;
          s_asi[s_cnt] = asi;     s_rd[s_cnt] = rdwr;
        end
        s_cnt++;
        pend = 1; cnt = waitc; la = bus_adr; lb = be_n;
      end
      if (rsp_valid) begin
        if (r_cnt < 8) begin
          r_data[r_cnt] = rsp_data; r_err[r_cnt] = rsp_err;
          r_isd[r_cnt] = rsp_is_data; r_sec[r_cnt] = rsp_second; r_cyc[r_cnt] = cyc;
        end
        r_cnt++;
      end
      if (pend && cnt == 0) begin
        rdy_n = 0;
        berr  = (beat_no == err_beat);
        if (lb == 4'b0000)      bus_d = wd(la[27:2]);
        else if (lb == 4'b0011) bus_d = {bb(la), bb(la + 28'd1), 16'hDEAD};
        else                    bus_d = {bb(la), 24'hC0FFEE};
        beat_no++;
        pend = 0;
      end else begin
        if (pend) cnt--;
        rdy_n = 1; berr = 0; bus_d = 32'hBADBAD00;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear(input int w, input int eb);
    @(negedge clk); #1;
    s_cnt = 0; r_cnt = 0; beat_no = 0; waitc = w; err_beat = eb;
  endtask

  task automatic wait_rsp(input int n);
    int k = 0;
    while (r_cnt < n && k < 200) begin @(negedge clk); #1; k++; end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic issue(input bit isd, input logic [25:0] w, input logic [3:0] a, input bit dbl);
    @(negedge clk);
    if (isd) begin d_valid = 1; d_wadr = w; d_asi = a; d_dbl = dbl; end
    else     begin i_valid = 1; i_wadr = w; i_asi = a; end
    #1;
    for (int k = 0; k < 100 && !(isd ? d_ack : i_ack); k++) begin @(negedge clk); #1; end
    ack_cyc = cyc;
    @(negedge clk);
    d_valid = 0; i_valid = 0; d_dbl = 0;
  endtask

  task automatic t_reset;
    #1;
    check("R11 as_n", as_n, 1);
    check("R11 rdwr", rdwr, 0);
    check("R11 be_n", be_n, 4'hF);
    check("R11 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_word32(input int w);
    logic [25:0] a = 26'h0000345;
    clear(w, -1);
    issue(1, a, 4'hA, 0);
    wait_rsp(1);
    check("R7 strobes", s_cnt, 1);
    check("R2 address", s_adr[0], {a, 2'b00});
    check("R2 asi", s_asi[0], 4'hA);
    check("R2 rdwr", s_rd[0], 1);
    check("R3 be_n 32", s_be[0], 4'b0000);
    check("R7 data", r_data[0], wd(a));
    check("R7 is_data", r_isd[0], 1);
    check("R4 latency", r_cyc[0] - ack_cyc, 2 + w);
  endtask

  task automatic t_half;
    logic [25:0] a = {2'b01, 24'h000ABC};
    clear(0, -1);
    issue(0, a, 4'h3, 0);
    wait_rsp(1);
    check("R5 beats", s_cnt, 2);
    check("R5 adr0", s_adr[0], {a, 2'b00});
    check("R5 adr1", s_adr[1], {a, 2'b10});
    check("R3 be_n 16", s_be[1], 4'b0011);
    check("R5 data", r_data[0], wd(a));
    check("R5 is_data", r_isd[0], 0);
  endtask

  task automatic t_byte;
    logic [25:0] a = {2'b10, 24'h0123F1};
    clear(1, -1);
    issue(1, a, 4'h5, 0);
    wait_rsp(1);
    check("R6 beats", s_cnt, 4);
    for (int k = 0; k < 4; k++) check("R6 adr", s_adr[k], {a, 2'(k)});
    check("R3 be_n 8", s_be[3], 4'b0111);
    check("R6 data", r_data[0], wd(a));
  endtask

  task automatic t_double;
    logic [25:0] a = {2'b11, 24'h00777F};
    clear(0, -1);
    issue(1, a, 4'h1, 1);
    wait_rsp(2);
    check("R8 strobes", s_cnt, 2);
    check("R8 adr1", s_adr[1], {a + 26'd1, 2'b00});
    check("R8 responses", r_cnt, 2);
    check("R8 word0", r_data[0], wd(a));
    check("R8 word1", r_data[1], wd(a + 26'd1));
    check("R8 second0", r_sec[0], 0);
    check("R8 second1", r_sec[1], 1);
    check("R8 back-to-back", r_cyc[1] - r_cyc[0], 1);
  endtask

  task automatic t_prio;
    logic [25:0] ad = 26'h0000100, ai = 26'h0000200;
    clear(2, -1);
    @(negedge clk);
    d_valid = 1; d_wadr = ad; d_asi = 4'h9; d_dbl = 0;
    i_valid = 1; i_wadr = ai; i_asi = 4'h8;
    #1;
    check("R1 d_ack", d_ack, 1);
    check("R1 i_ack", i_ack, 0);
    @(negedge clk);
    d_valid = 0;
    for (int k = 0; k < 100 && !i_ack; k++) begin @(negedge clk); #1; end
    check("R1 i waits for d rsp", r_cnt, 1);
    @(negedge clk);
    i_valid = 0;
    wait_rsp(2);
    check("R1 first is data", r_isd[0], 1);
    check("R1 data word", r_data[0], wd(ad));
    check("R1 second is instr", r_isd[1], 0);
    check("R1 instr word", r_data[1], wd(ai));
    check("R1 instr asi", s_asi[1], 4'h8);
  endtask

  task automatic t_err;
    logic [25:0] a = {2'b10, 24'h000040};
    clear(0, 1);
    issue(0, a, 4'h2, 0);
    wait_rsp(1);
    repeat (4) @(negedge clk);
    #1;
    check("R9 strobes", s_cnt, 2);
    check("R9 responses", r_cnt, 1);
    check("R9 err", r_err[0], 1);
    check("R9 tag", r_isd[0], 0);
    check("R9 rdwr idle", rdwr, 0);
  endtask

  task automatic t_grant;
    logic [25:0] a = 26'h0000050;
    clear(0, -1);
    @(negedge clk);
    grant = 0; d_valid = 1; d_wadr = a; d_asi = 4'h4; d_dbl = 0;
    for (int k = 0; k < 6; k++) begin
      #1;
      check("R10 no ack", {d_ack, i_ack}, 2'b00);
      @(negedge clk);
    end
    #1;
    check("R10 no strobe", s_cnt, 0);
    grant = 1;
    #1;
    check("R10 ack after grant", d_ack, 1);
    @(negedge clk);
    d_valid = 0;
    wait_rsp(1);
    check("R10 served", r_data[0], wd(a));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_word32(0);
    t_word32(3);
    t_half();
    t_byte();
    t_double();
    t_prio();
    t_err();
    t_grant();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule